// File: doc/BRIEF.md
# Square-Wave Channel Frequency Sweep Engine

This block changes the pitch of a square-wave sound channel over time by applying a periodic sweep. On a trigger it copies the channel's 11-bit frequency into a private shadow copy and reloads its sweep timer. An external frame sequencer supplies sweep ticks. Each time the timer expires, the block may compute a new frequency from the shadow, shifted and added or subtracted. It then writes that value back to the channel through a one-cycle strobe, or it requests that the channel be silenced when the result does not fit in 11 bits.

A small configuration register controls the block. Its fields are a 3-bit period in bits 6:4, a negate flag in bit 3 and a 3-bit shift in bits 2:0; bit 7 is stored but always reads back as 0. A separate channel-reset input clears that register and the flag that records whether a calculation has run. After at least one calculation since the last trigger, turning the negate flag off silences the channel at once.

Control uses three states. `SW_OFF`: the sweep is disabled and ticks only move the timer. `SW_ARMED`: the sweep is enabled and timer expiries cause calculations. `SW_RECHECK`: the single cycle after a write-back, in which the new shadow is checked for overflow a second time. The transitions are:
- trigger: to `SW_ARMED` when the period or the shift is nonzero, otherwise to `SW_OFF`.
- channel reset: to `SW_OFF`.
- expiry with a nonzero period, no overflow and a nonzero shift: from `SW_ARMED` to `SW_RECHECK`.
- always after one cycle: from `SW_RECHECK` back to `SW_ARMED`.

Top module: `tone_sweep_unit`

## Requirements
- R1: After reset, `freq_out` is 0, `freq_we` and `chan_kill` are low, and `cfg_rdata` is 0.
- R2: `cfg_rdata` returns the last value written with `cfg_wr`, with bit 7 forced to 0 (a write of 0xFF reads back 0x7F).
- R3: A `trig` pulse loads the shadow from `chan_freq`, reloads the timer and clears the calculation flag. The sweep becomes enabled only if the period (bits 6:4) or the shift (bits 2:0) is nonzero; while it is disabled, ticks never produce a write or a kill.
- R4: Each `sweep_tick` decrements the timer. The tick that finds the timer at 1 is an expiry and reloads the timer with the period, or with 8 when the period is 0. After a trigger with period P, the P-th tick (8th when P is 0) is the first expiry.
- R5: On an expiry while enabled with a nonzero period, the new frequency is shadow + (shadow >> shift). When the negate flag (bit 3) is set it is shadow - (shadow >> shift) instead. This marks a calculation as performed.
- R6: If that new frequency exceeds 2047, `chan_kill` pulses one cycle after the expiring tick and nothing is written back.
- R7: If the shift is nonzero and there is no overflow, `freq_out` takes the new value and `freq_we` pulses one cycle after the expiring tick, and the shadow takes the same value. With a shift of 0 nothing is written.
- R8: In the cycle after a write-back, the new shadow is recalculated. If that result exceeds 2047, `chan_kill` pulses two cycles after the expiring tick, without a write.
- R9: A `cfg_wr` that changes bit 3 from 1 to 0 pulses `chan_kill` one cycle later, but only if a calculation has been performed since the last trigger.
- R10: `chan_reset` clears the register (reads 0), clears the calculation flag and disables the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_reset | input | 1 | Channel reset pulse: clears the register and the calculation flag |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write value |
| cfg_rdata | output | 8 | Register read value, bit 7 forced to 0 |
| trig | input | 1 | Channel trigger pulse |
| sweep_tick | input | 1 | Sweep clock tick from the frame sequencer |
| chan_freq | input | 11 | Current channel frequency |
| freq_out | output | 11 | Last frequency written back |
| freq_we | output | 1 | One-cycle strobe: `freq_out` is new |
| chan_kill | output | 1 | One-cycle request to disable the channel |

Ticks are at least two cycles apart. `trig`, `cfg_wr` and `chan_reset` are never asserted in the same cycle.

## Verification
The hardest case to reach from the ports is the second overflow check. It needs a shadow whose first sweep result still fits in 11 bits but whose second does not. The stimulus triggers with 0x500 and a shift of 1: the first expiry writes 0x780, and the kill follows one cycle later. A second hard case is the period-0 reload to 8, which produces no calculation by itself. To observe it, the stimulus triggers with period 0 and then reprograms period 1. A write must then appear on exactly the 8th tick.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    typedef enum logic [1:0] {
        SW_OFF     = 2'd0,
        SW_ARMED   = 2'd1,
        SW_RECHECK = 2'd2
    } sweep_state_e;
endpackage

// File: rtl/sweep_timer.sv
module sweep_timer #(
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             expire
);
    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // a zero period still runs the timer, over the longest span
    assign reload = (period == '0) ? CNT_W'(1 << PER_W) : {1'b0, period};
    assign expire = tick && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (tick)
            cnt_q <= expire ? reload : cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/sweep_calc.sv
module sweep_calc #(
    parameter int FREQ_W = 11,
    parameter int SHF_W  = 3
) (
    input  logic [FREQ_W-1:0] shadow,
    input  logic [SHF_W-1:0]  shift,
    input  logic              negate,
    output logic [FREQ_W-1:0] next_freq,
    output logic              ovf
);
    logic [FREQ_W-1:0] delta;
    logic [FREQ_W:0]   sum;

    assign delta = shadow >> shift;
    // subtraction never borrows: delta <= shadow
    assign sum = negate ? ({1'b0, shadow} - {1'b0, delta})
                        : ({1'b0, shadow} + {1'b0, delta});
    assign next_freq = sum[FREQ_W-1:0];
    assign ovf       = sum[FREQ_W];
endmodule

// File: rtl/tone_sweep_unit.sv
module tone_sweep_unit
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 11,
    parameter int PER_W  = 3,
    parameter int SHF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_reset,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              trig,
    input  logic              sweep_tick,
    input  logic [FREQ_W-1:0] chan_freq,
    output logic [FREQ_W-1:0] freq_out,
    output logic              freq_we,
    output logic              chan_kill
);
    localparam int NEG_BIT = SHF_W;
    localparam int PER_LO  = SHF_W + 1;
    localparam int PER_HI  = PER_LO + PER_W - 1;

    logic [7:0]        cfg_q;
    logic [PER_W-1:0]  period;
    logic [SHF_W-1:0]  shift;
    logic              negate;
    logic              expire;
    logic              neg_clear;
    logic              calc_due;
    logic              calc_done_q;
    logic [FREQ_W-1:0] shadow_q;
    logic [FREQ_W-1:0] calc_freq;
    logic              calc_ovf;
    sweep_state_e      state_q, state_d;

    assign period    = cfg_q[PER_HI:PER_LO];
    assign shift     = cfg_q[SHF_W-1:0];
    assign negate    = cfg_q[NEG_BIT];
    assign cfg_rdata = {1'b0, cfg_q[6:0]};
    assign neg_clear = cfg_wr && negate && !cfg_wdata[NEG_BIT];
    assign calc_due  = (state_q == SW_ARMED) && expire && (period != '0);

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (chan_reset)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_wdata;
    end

    sweep_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (trig),
        .tick   (sweep_tick),
        .period (period),
        .expire (expire)
    );

    sweep_calc #(.FREQ_W(FREQ_W), .SHF_W(SHF_W)) u_calc (
        .shadow    (shadow_q),
        .shift     (shift),
        .negate    (negate),
        .next_freq (calc_freq),
        .ovf       (calc_ovf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SW_OFF;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (chan_reset) begin
            state_d = SW_OFF;
        end else if (trig) begin
            state_d = ((period != '0) || (shift != '0)) ? SW_ARMED : SW_OFF;
        end else begin
            unique case (state_q)
                SW_OFF:     state_d = SW_OFF;
                SW_ARMED:   if (calc_due && !calc_ovf && (shift != '0))
                                state_d = SW_RECHECK;
                SW_RECHECK: state_d = SW_ARMED;
                default:    state_d = SW_OFF;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q    <= '0;
            calc_done_q <= 1'b0;
            freq_out    <= '0;
            freq_we     <= 1'b0;
            chan_kill   <= 1'b0;
        end else begin
            freq_we   <= 1'b0;
            chan_kill <= 1'b0;
            if (chan_reset) begin
                calc_done_q <= 1'b0;
            end else if (trig) begin
                shadow_q    <= chan_freq;
                calc_done_q <= 1'b0;
            end else begin
                if (neg_clear && calc_done_q)
                    chan_kill <= 1'b1;
                unique case (state_q)
                    SW_ARMED: begin
                        if (calc_due) begin
                            calc_done_q <= 1'b1;
                            if (calc_ovf) begin
                                chan_kill <= 1'b1;
                            end else if (shift != '0) begin
                                shadow_q <= calc_freq;
                                freq_out <= calc_freq;
                                freq_we  <= 1'b1;
                            end
                        end
                    end
                    SW_RECHECK: if (calc_ovf) chan_kill <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tone_sweep_unit_sva.sv
module tone_sweep_unit_sva #(
    parameter int FREQ_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [7:0]        cfg_rdata,
    input logic              sweep_tick,
    input logic [FREQ_W-1:0] freq_out,
    input logic              freq_we,
    input logic              chan_kill
);
    // R2: bit 7 never reads as set
    a_r2_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0);

    // R7: a write-back is always caused by a tick one cycle earlier
    a_r7_we_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        freq_we |-> $past(sweep_tick));

    // R8: a write-back is followed by a check cycle, never a second write
    a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        freq_we |=> !freq_we);

    // R7: the frequency output only moves together with its strobe
    a_r7_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_out) |-> freq_we);

    // R9: a kill has a tick, a write-back or a register write behind it
    a_r9_kill_cause: assert property (@(posedge clk) disable iff (!rst_n)
        chan_kill |-> ($past(sweep_tick) || $past(freq_we) || $past(cfg_wr)));
endmodule

bind tone_sweep_unit tone_sweep_unit_sva #(.FREQ_W(FREQ_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_rdata  (cfg_rdata),
    .sweep_tick (sweep_tick),
    .freq_out   (freq_out),
    .freq_we    (freq_we),
    .chan_kill  (chan_kill)
);

// File: tb/sim_tone_sweep_unit.sv
`timescale 1ns/1ps
module sim_tone_sweep_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_reset = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        trig = 1'b0;
    logic        sweep_tick = 1'b0;
    logic [10:0] chan_freq = '0;
    logic [10:0] freq_out;
    logic        freq_we;
    logic        chan_kill;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    tone_sweep_unit u0 (
        .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .trig(trig), .sweep_tick(sweep_tick), .chan_freq(chan_freq),
        .freq_out(freq_out), .freq_we(freq_we), .chan_kill(chan_kill)
    );

    // behavioural reference
    int m_cfg, m_shadow, m_timer, m_state, m_calc, m_fout, m_we, m_kill;

    always @(posedge clk or negedge rst_n) begin : model
        int per, shf, neg, rl, d, nf, nxt_cfg;
        bit expd;
        if (!rst_n) begin
            m_cfg = 0; m_shadow = 0; m_timer = 0; m_state = 0;
            m_calc = 0; m_fout = 0; m_we = 0; m_kill = 0;
        end else begin
            per = (m_cfg >> 4) & 7;
            shf = m_cfg & 7;
            neg = (m_cfg >> 3) & 1;
            rl  = (per == 0) ? 8 : per;
            expd = sweep_tick && (m_timer <= 1);
            d  = m_shadow >> shf;
            nf = neg ? m_shadow - d : m_shadow + d;
            m_we = 0; m_kill = 0;
            nxt_cfg = chan_reset ? 0 : (cfg_wr ? int'(cfg_wdata) : m_cfg);
            if (trig) m_timer = rl;
            else if (sweep_tick) m_timer = expd ? rl : m_timer - 1;
            if (chan_reset) begin
                m_calc = 0; m_state = 0;
            end else if (trig) begin
                m_shadow = chan_freq; m_calc = 0;
                m_state = (per != 0 || shf != 0) ? 1 : 0;
            end else begin
                if (cfg_wr && neg == 1 && !cfg_wdata[3] && m_calc == 1) m_kill = 1;
                if (m_state == 1 && expd && per != 0) begin
                    m_calc = 1;
                    if (nf > 2047) m_kill = 1;
                    else if (shf != 0) begin
                        m_shadow = nf; m_fout = nf; m_we = 1; m_state = 2;
                    end
                end else if (m_state == 2) begin
                    if (nf > 2047) m_kill = 1;
                    m_state = 1;
                end
            end
            m_cfg = nxt_cfg;
        end
    end

    task automatic expect_eq(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            expect_eq("R7", "model freq_out", int'(freq_out), m_fout);
            expect_eq("R7", "model freq_we", int'(freq_we), m_we);
            expect_eq("R6", "model chan_kill", int'(chan_kill), m_kill);
            expect_eq("R2", "model cfg_rdata", int'(cfg_rdata), m_cfg & 8'h7f);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic fire(logic [10:0] f);
        @(negedge clk); trig = 1'b1; chan_freq = f;
        @(negedge clk); trig = 1'b0;
    endtask

    // returns at the first negedge after the tick was taken
    task automatic tick();
        @(negedge clk); sweep_tick = 1'b1;
        @(negedge clk); sweep_tick = 1'b0;
    endtask

    initial begin : watchdog
        #(20ns * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(2);
        // R1: reset state
        expect_eq("R1", "freq_out", int'(freq_out), 0);
        expect_eq("R1", "freq_we", int'(freq_we), 0);
        expect_eq("R1", "chan_kill", int'(chan_kill), 0);
        expect_eq("R1", "cfg_rdata", int'(cfg_rdata), 0);
        @(negedge clk); rst_n = 1'b1;

        phase = "R2";
        wr(8'hFF);
        expect_eq("R2", "read 0xFF", int'(cfg_rdata), 8'h7F);

        // R3 / R5 / R7: add sweep, period 1, shift 1
        wr(8'h11); fire(11'h100);
        tick();
        expect_eq("R7", "write 0x180", int'(freq_out), 11'h180);
        expect_eq("R7", "strobe", int'(freq_we), 1);
        idle(1);
        tick();
        expect_eq("R5", "second step 0x240", int'(freq_out), 11'h240);

        // R7: shift 0 gives no write
        wr(8'h10); fire(11'h100); tick();
        expect_eq("R7", "shift0 no strobe", int'(freq_we), 0);

        // R8: first result fits, second overflows
        wr(8'h11); fire(11'h500); tick();
        expect_eq("R8", "first write 0x780", int'(freq_out), 11'h780);
        expect_eq("R8", "no kill yet", int'(chan_kill), 0);
        @(negedge clk);
        expect_eq("R8", "recheck kill", int'(chan_kill), 1);

        // R6: immediate overflow
        fire(11'h700); tick();
        expect_eq("R6", "overflow kill", int'(chan_kill), 1);
        expect_eq("R6", "no strobe", int'(freq_we), 0);

        // R5: negate, then R9 negate clear after a calculation
        wr(8'h19); fire(11'h400); tick();
        expect_eq("R5", "negate 0x200", int'(freq_out), 11'h200);
        idle(1);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 8'h11;
        @(negedge clk); cfg_wr = 1'b0;
        expect_eq("R9", "negate clear kill", int'(chan_kill), 1);
        fire(11'h400); wr(8'h19);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 8'h11;
        @(negedge clk); cfg_wr = 1'b0;
        expect_eq("R9", "no calc no kill", int'(chan_kill), 0);

        // R4: period 0 reloads with 8
        phase = "R4";
        wr(8'h01); fire(11'h100); wr(8'h11);
        for (int i = 1; i <= 7; i++) begin
            tick();
            expect_eq("R4", "before 8th tick", int'(freq_we), 0);
            idle(1);
        end
        tick();
        expect_eq("R4", "8th tick writes", int'(freq_we), 1);
        idle(1);
        // period 3
        wr(8'h31); fire(11'h100);
        tick(); expect_eq("R4", "p3 tick1", int'(freq_we), 0); idle(1);
        tick(); expect_eq("R4", "p3 tick2", int'(freq_we), 0); idle(1);
        tick(); expect_eq("R4", "p3 tick3", int'(freq_we), 1); idle(1);

        // R3: period and shift zero on trigger leaves the sweep off
        wr(8'h00); fire(11'h100); wr(8'h11);
        for (int i = 0; i < 10; i++) begin
            tick();
            expect_eq("R3", "disabled no write", int'(freq_we), 0);
            idle(1);
        end

        // R10: channel reset
        wr(8'h19); fire(11'h400); tick(); idle(1);
        @(negedge clk); chan_reset = 1'b1;
        @(negedge clk); chan_reset = 1'b0;
        expect_eq("R10", "reg cleared", int'(cfg_rdata), 0);
        wr(8'h08); wr(8'h00);
        expect_eq("R10", "calc flag cleared", int'(chan_kill), 0);
        wr(8'h11);
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_eq("R10", "sweep off", int'(freq_we), 0);
            idle(1);
        end

        idle(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule